// File: doc/BRIEF.md
# Reaction Guessing Game Controller

A clocked game controller that walks a single lit lamp around four positions and judges which of four buttons the player presses. A press is compared with the lamp that was lit before the clock edge. Pressing exactly the matching button stops play in a neutral "good" state. Pressing any other button stops play in an error state, and this holds even if the matching button is pressed at the same time. While play is stopped every lamp is dark. The machine waits there until all buttons are released, then restarts from the first lamp.

Lamp movement is made irregular by a built-in 8-bit linear feedback shift register that steps on every clock. Its low bit acts as a step enable. The lamp moves forward only in cycles where that bit is 1, but a press is judged on every clock whatever the bit's value. The buttons are assumed to be debounced and synchronous to the clock.

Top module: `reaction_game`

## Requirements
- R1: A synchronous active-high reset puts the machine in the stopped-good state, with all lamps and the error lamp dark. It also loads the shift register with the seed 8'h01.
- R2: In either stopped state (all lamps dark), the state is held while any button is pressed. With all buttons released, the next clock lights lamp 0 (`lamp` = 4'b0001) and clears the error lamp.
- R3: With lamp i lit and only button i pressed (`btn[i]` is 1, all other bits 0), the next state is stopped-good: all lamps dark and error lamp off.
- R4: With lamp i lit and any button other than i pressed, whether or not button i is also pressed, the next state is the error state: `err` is 1 and all lamps are dark.
- R5: With a lamp lit and no button pressed, the lamp advances from bit i to bit i+1, and from bit 3 back to bit 0, only when the step enable is 1. When the step enable is 0 the lamp holds.
- R6: The step enable is bit 0 of an 8-bit register. On each clock the register shifts left by one bit and takes into bit 0 the XOR of its bits 7, 5, 4 and 3. This gives the polynomial x^8+x^6+x^5+x^4+1, so the sequence repeats every 255 clocks and never reaches zero.
- R7: Presses are judged on every clock, including clocks where the step enable is 0.
- R8: At most one of the five outputs (`lamp[3:0]`, `err`) is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn | input | 4 | Button inputs, bit i pairs with lamp i |
| lamp | output | 4 | One-hot lamp outputs, dark while stopped |
| err | output | 1 | Error lamp, lit only in the error state |

## Verification
The assertions assume that the buttons are clean, synchronous levels: sampled once per clock edge, with no bounce and no change close to the edge. The bench meets this by changing `btn` only on the falling clock edge and holding it for whole cycles. The assertions also assume that reset is applied before the first rising edge that matters, so the shift register never starts from an unknown or zero value. The bench raises reset from time zero and raises it again in the middle of play.

// File: rtl/reaction_game.sv
module reaction_game #(
  parameter int LAMPS  = 4,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] FB_MASK = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED    = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAMPS-1:0] btn,
  output logic [LAMPS-1:0] lamp,
  output logic             err
);
  localparam int SW = LAMPS + 1;
  localparam logic [SW-1:0] ST_OK    = '0;
  localparam logic [SW-1:0] ST_ERR   = SW'(1) << LAMPS;
  localparam logic [SW-1:0] ST_FIRST = SW'(1);

  logic [SW-1:0]     st, st_nx;
  logic [LFSR_W-1:0] lfsr;
  logic              sen, fb, lit, stopped;
  logic [LAMPS-1:0]  cur, rot;

  assign fb  = ^(lfsr & FB_MASK);
  assign sen = lfsr[0];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= {lfsr[LFSR_W-2:0], fb};
  end

  assign cur     = st[LAMPS-1:0];
  assign rot     = {cur[LAMPS-2:0], cur[LAMPS-1]};
  assign stopped = (cur == '0);
  assign lit     = !st[LAMPS] && ($countones(cur) == 1);

  always_comb begin
    st_nx = st;
    if (stopped) begin
      if (btn == '0) st_nx = ST_FIRST;
    end else if (lit) begin
      if ((btn & ~cur) != '0) st_nx = ST_ERR;
      else if (btn != '0)     st_nx = ST_OK;
      else if (sen)           st_nx = {1'b0, rot};
    end else begin
      st_nx = ST_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_OK;
    else     st <= st_nx;
  end

  assign lamp = cur;
  assign err  = st[LAMPS];
endmodule

// File: rtl/game_chk.sv
module game_chk #(
  parameter int L = 4,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [L-1:0] btn,
  input logic [L-1:0] lamp,
  input logic         err,
  input logic         sen,
  input logic [W-1:0] lfsr
);
  // R8
  outputs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err, lamp}));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp == '0 && btn == '0) |=> (lamp == L'(1) && !err));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp == '0 && btn != '0) |=> ($stable(lamp) && $stable(err)));

  // R3
  good_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp != '0 && btn != '0 && (btn & ~lamp) == '0) |=> (lamp == '0 && !err));

  // R4
  wrong_press_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp != '0 && (btn & ~lamp) != '0) |=> (err && lamp == '0));

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp != '0 && btn == '0 && sen) |=> (lamp == $past({lamp[L-2:0], lamp[L-1]})));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp != '0 && btn == '0 && !sen) |=> $stable(lamp));

  // R6
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

bind reaction_game game_chk #(.L(LAMPS), .W(LFSR_W)) chk_i (
  .clk(clk), .rst(rst), .btn(btn), .lamp(lamp), .err(err),
  .sen(sen), .lfsr(lfsr)
);

// File: tb/reaction_game_tb_top.sv
module reaction_game_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] btn = 4'b0;
  logic [3:0] lamp;
  logic       err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [4:0] q_exp[$];
  string      q_tag[$];

  logic [4:0] m_st;
  logic [7:0] m_lfsr;
  int         since_rst;

  always #2.5 clk = ~clk;

  reaction_game dut_i (.clk(clk), .rst(rst), .btn(btn), .lamp(lamp), .err(err));

  function automatic logic [4:0] model_next(logic [4:0] s, logic [3:0] b, logic en);
    logic [3:0] l;
    l = s[3:0];
    if (l == 4'b0) return (b == 4'b0) ? 5'b00001 : s;
    if ((b & ~l) != 4'b0) return 5'b10000;
    if (b != 4'b0) return 5'b00000;
    if (en) return {1'b0, l[2:0], l[3]};
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    btn = 4'b0;
    @(posedge clk);
    #1;
    checks++;
    if (lamp != 4'b0 || err != 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual lamp=%b err=%b expected lamp=0000 err=0", lamp, err);
    end
    @(negedge clk);
    rst = 1'b0;
    m_st = 5'b0;
    m_lfsr = 8'h01;
    since_rst = 0;
  endtask

  // called at a falling edge; drives one cycle and queues the expectation
  task automatic step(logic [3:0] b);
    logic       en;
    logic [4:0] nx;
    string      tag;
    en = m_lfsr[0];
    btn = b;
    nx = model_next(m_st, b, en);
    if (m_st[3:0] == 4'b0) tag = "R2";
    else if ((b & ~m_st[3:0]) != 4'b0) tag = "R4";
    else if (b != 4'b0) tag = en ? "R3" : "R7";
    else tag = (since_rst >= 255) ? "R6" : "R5";
    q_exp.push_back(nx);
    q_tag.push_back(tag);
    m_st = nx;
    m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    since_rst++;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && q_exp.size() > 0) begin
      logic [4:0] e;
      string      t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({err, lamp} !== e) begin
        errors++;
        $display("FAIL %s: actual err/lamp=%b expected %b", t, {err, lamp}, e);
      end
      checks++;
      if ($countones({err, lamp}) > 1) begin
        errors++;
        $display("FAIL R8: actual err/lamp=%b expected at most one bit set", {err, lamp});
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(4'b0);
  endtask

  task automatic hit_right(int hold);
    logic [3:0] l;
    l = m_st[3:0];
    for (int i = 0; i < hold; i++) step(l);
    idle(2);
  endtask

  task automatic hit_wrong(logic with_right, int hold);
    logic [3:0] l, b;
    l = m_st[3:0];
    b = {l[2:0], l[3]};
    if (with_right) b = b | l;
    for (int i = 0; i < hold; i++) step(b);
    idle(2);
  endtask

  initial begin
    do_reset();
    idle(20);
    hit_right(3);
    idle(5);
    hit_wrong(1'b0, 3);
    idle(7);
    hit_wrong(1'b1, 2);
    idle(3);
    for (int k = 0; k < 6; k++) begin
      while (m_lfsr[0] != 1'b0) step(4'b0);
      if (k % 2 == 0) hit_right(1);
      else hit_wrong(1'b0, 1);
    end
    idle(300);
    step(4'b1111);
    step(4'b0);
    idle(4);
    do_reset();
    idle(10);
    hit_right(2);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule